// File: doc/BRIEF.md
# Accumulator Processor with Handshaked Memory Port

This block is a small single-address processor built around one accumulator. It fetches 16-bit instruction words from an external word-addressed memory and decodes each one. It then loads, adds or stores one operand word at the 12-bit address carried in the instruction. A program counter steps through the instruction words. Every transfer, instruction or operand, passes through a memory address register and a memory buffer register. No access ever assumes a fixed latency.

The memory side is a strobe and acknowledge port. The core raises a read or write strobe with a registered address and write data. It keeps the strobe high until the memory reports that the access has finished. It then drops the strobe and lets the acknowledge fall before it starts anything new. The acknowledge may come from another timing domain, so it passes through a configurable synchronizer first. The accumulator and the carry of the last addition are brought out for the surrounding logic.

Top module: `acc_cpu_core`

## Requirements
- R1: An instruction word splits into an opcode (bits 15..12) and an operand address (bits 11..0). The operand access uses all 12 address bits unchanged on `mem_addr_o`.
- R2: Opcode 4'b0000 copies the addressed word into the accumulator and leaves the carry flag unchanged.
- R3: Opcode 4'b1000 adds the addressed word to the accumulator modulo 2^16. Bit 16 of the sum becomes the carry flag.
- R4: Opcode 4'b0001 issues one write of the accumulator value to the operand address.
- R5: Any other opcode makes no operand access and changes neither the accumulator nor the carry. The next fetch comes from the following address.
- R6: Instruction fetches read consecutive addresses starting at 0. The program counter advances by exactly one per fetch.
- R7: A strobe stays high until the synchronized completion is seen. Read data is taken only on completion, and a write does not end before it.
- R8: After a strobe falls, both strobes stay low for at least one cycle. No new access starts while completion is still high.
- R9: The read and write strobes are never high together.
- R10: A synchronous active-high reset clears the accumulator, carry, program counter, datapath registers and strobes. After reset the first access is an instruction fetch from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | 12 | Registered word address of the current access |
| mem_wdata_o | output | 16 | Registered write data |
| mem_rdata_i | input | 16 | Read data, valid while completion is high |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_done_i | input | 1 | Access-complete acknowledge, may be asynchronous |
| acc_o | output | 16 | Accumulator value |
| carry_o | output | 1 | Carry out of the last addition |

## Verification
The bench builds the core with its default 16-bit word and a two-stage acknowledge synchronizer. It therefore exercises the case where completion stays visible inside the core for two cycles after the memory has already dropped it. Its memory model answers each access after a delay of 0 to 5 cycles, and the delay pattern shifts between runs. This brings the zero-wait acknowledge and the long stalls within reach for fetches, operand reads and writes alike. Eight operand pairs cover the add corners: zero, all-ones, wrap with and without carry, and the sign boundary. Each run uses a different undefined opcode as the no-operation, and every access address and direction is compared against the sequence computed from the program.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_LOAD  = 4'b0000,
    OPC_ADD   = 4'b1000,
    OPC_STORE = 4'b0001
  } opc_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_FWAIT,
    ST_FDRAIN,
    ST_DECODE,
    ST_RWAIT,
    ST_EXEC,
    ST_WWAIT,
    ST_DRAIN
  } ctl_state_e;

  // load enables from controller to datapath
  typedef struct packed {
    logic pc_inc;
    logic mar_pc;
    logic mar_ir;
    logic mbr_mem;
    logic mbr_acc;
    logic ir_ld;
    logic acc_ld;
    logic acc_add;
  } dp_ctl_t;

endpackage

// File: rtl/acc_cpu_sync.sv
module acc_cpu_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
      end
      assign sync_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             done_s_i,
  input  logic [OPC_W-1:0] opc_i,
  output dp_ctl_t          ctl_o,
  output logic             rd_o,
  output logic             wr_o
);

  ctl_state_e state_q, state_d;
  logic       rd_q, rd_d;
  logic       wr_q, wr_d;
  logic       is_add_q, is_add_d;
  logic       strobe_prev_q;
  logic       done_prev_q;
  dp_ctl_t    ctl;

  always_comb begin
    state_d  = state_q;
    rd_d     = rd_q;
    wr_d     = wr_q;
    is_add_d = is_add_q;
    ctl      = '0;
    unique case (state_q)
      ST_FETCH: begin
        ctl.mar_pc = 1'b1;
        rd_d       = 1'b1;
        state_d    = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (done_s_i) begin
          ctl.mbr_mem = 1'b1;
          ctl.pc_inc  = 1'b1;
          rd_d        = 1'b0;
          state_d     = ST_FDRAIN;
        end
      end
      ST_FDRAIN: begin
        ctl.ir_ld = 1'b1;
        if (!done_s_i) state_d = ST_DECODE;
      end
      ST_DECODE: begin
        case (opc_i)
          OPC_LOAD, OPC_ADD: begin
            ctl.mar_ir = 1'b1;
            rd_d       = 1'b1;
            is_add_d   = (opc_i == OPC_ADD);
            state_d    = ST_RWAIT;
          end
          OPC_STORE: begin
            ctl.mar_ir  = 1'b1;
            ctl.mbr_acc = 1'b1;
            wr_d        = 1'b1;
            state_d     = ST_WWAIT;
          end
          default: state_d = ST_FETCH;
        endcase
      end
      ST_RWAIT: begin
        if (done_s_i) begin
          ctl.mbr_mem = 1'b1;
          rd_d        = 1'b0;
          state_d     = ST_EXEC;
        end
      end
      ST_EXEC: begin
        ctl.acc_add = is_add_q;
        ctl.acc_ld  = !is_add_q;
        state_d     = ST_DRAIN;
      end
      ST_WWAIT: begin
        if (done_s_i) begin
          wr_d    = 1'b0;
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!done_s_i) state_d = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_FETCH;
      rd_q          <= 1'b0;
      wr_q          <= 1'b0;
      is_add_q      <= 1'b0;
      strobe_prev_q <= 1'b0;
      done_prev_q   <= 1'b0;
    end else begin
      state_q       <= state_d;
      rd_q          <= rd_d;
      wr_q          <= wr_d;
      is_add_q      <= is_add_d;
      strobe_prev_q <= rd_q | wr_q;
      done_prev_q   <= done_s_i;
    end
  end

  assign ctl_o = ctl;
  assign rd_o  = rd_q;
  assign wr_o  = wr_q;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));

  assert_hold_rd_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_q && !done_s_i) |=> rd_q);

  assert_hold_wr_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_q && !done_s_i) |=> wr_q);

  assert_low_gap_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe_prev_q && !(rd_q || wr_q)) |=> !(rd_q || wr_q));

  assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!strobe_prev_q && (rd_q || wr_q)) |-> !done_prev_q);

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned ADDR_W = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_ctl_t           ctl_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [WORD_W-1:0] mbr_o,
  output logic [OPC_W-1:0]  opc_o,
  output logic [WORD_W-1:0] acc_o,
  output logic              carry_o
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [WORD_W-1:0] mbr_q;
  logic [WORD_W-1:0] ir_q;
  logic [WORD_W-1:0] acc_q;
  logic              carry_q;
  logic [WORD_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, mbr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mbr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (ctl_i.pc_inc) pc_q <= pc_q + 1'b1;
      if (ctl_i.mar_pc)      mar_q <= pc_q;
      else if (ctl_i.mar_ir) mar_q <= ir_q[ADDR_W-1:0];
      if (ctl_i.mbr_mem)      mbr_q <= rdata_i;
      else if (ctl_i.mbr_acc) mbr_q <= acc_q;
      if (ctl_i.ir_ld) ir_q <= mbr_q;
      if (ctl_i.acc_add) begin
        acc_q   <= sum[WORD_W-1:0];
        carry_q <= sum[WORD_W];
      end else if (ctl_i.acc_ld) begin
        acc_q   <= mbr_q;
      end
    end
  end

  assign mar_o   = mar_q;
  assign mbr_o   = mbr_q;
  assign opc_o   = ir_q[WORD_W-1 -: OPC_W];
  assign acc_o   = acc_q;
  assign carry_o = carry_q;

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
    ctl_i.pc_inc |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  assert_pc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ctl_i.pc_inc |=> $stable(pc_q));

  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.acc_ld && !ctl_i.acc_add) |=> $stable(acc_q));

  assert_carry_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl_i.acc_add |=> $stable(carry_q));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic              mem_done_i,
  output logic [WORD_W-1:0] acc_o,
  output logic              carry_o
);

  logic             done_s;
  logic [OPC_W-1:0] opc;
  dp_ctl_t          ctl;

  acc_cpu_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i (mem_done_i),
    .sync_o  (done_s)
  );

  acc_cpu_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .done_s_i (done_s),
    .opc_i    (opc),
    .ctl_o    (ctl),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o)
  );

  acc_cpu_dpath #(.WORD_W(WORD_W)) dpath_i (
    .clk     (clk),
    .rst     (rst),
    .ctl_i   (ctl),
    .rdata_i (mem_rdata_i),
    .mar_o   (mem_addr_o),
    .mbr_o   (mem_wdata_o),
    .opc_o   (opc),
    .acc_o   (acc_o),
    .carry_o (carry_o)
  );

endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 256;
  localparam int N_ACC      = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rd, mem_wr;
  logic        mem_done = 1'b0;
  logic [15:0] acc;
  logic        carry;

  int total = 0;
  int bad   = 0;

  logic [15:0] mem [MEM_N];
  int  lat_base = 0;
  int  acc_idx  = 0;
  int  cnt      = 0;
  bit  prev_strobe = 0;
  bit  done_seen   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_core #(.WORD_W(16), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_done_i(mem_done),
    .acc_o(acc), .carry_o(carry)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  localparam logic [11:0] A_ADR = 12'hA80, B_ADR = 12'h581, C_ADR = 12'hF82;
  localparam logic [11:0] D_ADR = 12'h083, E_ADR = 12'h784, F_ADR = 12'h2C5;

  // expected access i: {write, address}
  function automatic logic [12:0] exp_access(input int i);
    case (i)
      0: return {1'b0, 12'd0};
      1: return {1'b0, A_ADR};
      2: return {1'b0, 12'd1};
      3: return {1'b0, B_ADR};
      4: return {1'b0, 12'd2};
      5: return {1'b1, C_ADR};
      6: return {1'b0, 12'd3};
      7: return {1'b0, 12'd4};
      8: return {1'b1, D_ADR};
      9: return {1'b0, 12'd5};
      10: return {1'b0, E_ADR};
      11: return {1'b0, 12'd6};
      12: return {1'b1, F_ADR};
      default: return {1'b0, 12'(7 + i - 13)};
    endcase
  endfunction

  // behavioural memory with variable latency, plus port monitor
  always @(negedge clk) begin
    if (rst) begin
      mem_done    = 1'b0;
      cnt         = 0;
      prev_strobe = 0;
      acc_idx     = 0;
      done_seen   = 0;
    end else begin
      if ((mem_rd | mem_wr) && !prev_strobe) begin
        check(mem_addr == exp_access(acc_idx)[11:0] && mem_wr == exp_access(acc_idx)[12],
              "R1/R6 access address and direction", {19'd0, mem_wr, mem_addr}, {19'd0, exp_access(acc_idx)});
        check(!mem_done, "R8 no start while completion high", 32'(mem_done), 0);
        check(!(mem_rd && mem_wr), "R9 single strobe", {mem_rd, mem_wr}, 0);
        done_seen = 0;
        cnt = 0;
      end
      if (!(mem_rd | mem_wr) && prev_strobe) begin
        check(done_seen, "R7 strobe held to completion", 32'(done_seen), 1);
        acc_idx++;
      end
      if ((mem_rd | mem_wr) && !mem_done) begin
        if (cnt >= (lat_base + acc_idx * 3) % 6) begin
          mem_done  = 1'b1;
          done_seen = 1;
          if (mem_wr) mem[mem_addr[7:0]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[7:0]];
        end else begin
          cnt++;
        end
      end else if (!(mem_rd | mem_wr) && mem_done) begin
        mem_done  = 1'b0;
        mem_rdata = 16'hDEAD;
      end
      prev_strobe = mem_rd | mem_wr;
    end
  end

  function automatic logic [3:0] nop_opc(input int k);
    case (k)
      0: return 4'h2; 1: return 4'h3; 2: return 4'h4; 3: return 4'h5;
      4: return 4'h9; 5: return 4'hC; 6: return 4'hE; default: return 4'h7;
    endcase
  endfunction

  initial begin
    bit hung = 0;
    for (int k = 0; k < 8 && !hung; k++) begin
      logic [15:0] a, b, v;
      logic [16:0] s;
      int cyc;
      case (k)
        0: begin a = 16'h0000; b = 16'h0000; end
        1: begin a = 16'h0001; b = 16'hFFFF; end
        2: begin a = 16'hFFFF; b = 16'hFFFF; end
        3: begin a = 16'h8000; b = 16'h8000; end
        4: begin a = 16'h1234; b = 16'h4321; end
        5: begin a = 16'h7FFF; b = 16'h0001; end
        6: begin a = 16'hFFFF; b = 16'h0000; end
        default: begin a = 16'h00FF; b = 16'hFF01; end
      endcase
      v = a ^ 16'h5A5A;
      s = {1'b0, a} + {1'b0, b};
      rst = 1'b1;
      lat_base = k;
      for (int i = 0; i < MEM_N; i++) mem[i] = 16'hF000;
      mem[0] = {4'b0000, A_ADR};
      mem[1] = {4'b1000, B_ADR};
      mem[2] = {4'b0001, C_ADR};
      mem[3] = {nop_opc(k), 12'hABC};
      mem[4] = {4'b0001, D_ADR};
      mem[5] = {4'b0000, E_ADR};
      mem[6] = {4'b0001, F_ADR};
      mem[A_ADR[7:0]] = a;
      mem[B_ADR[7:0]] = b;
      mem[E_ADR[7:0]] = v;
      repeat (3) @(negedge clk);
      // R10: state cleared while in reset
      check(acc == 16'h0 && carry == 1'b0, "R10 reset clears acc/carry", {15'd0, carry, acc}, 0);
      check(!mem_rd && !mem_wr, "R10 reset strobes low", {mem_rd, mem_wr}, 0);
      @(posedge clk);
      #1 rst = 1'b0;
      cyc = 0;
      while (acc_idx < N_ACC && cyc < 3000) begin
        @(negedge clk);
        cyc++;
      end
      if (acc_idx < N_ACC) begin
        check(0, "watchdog expired", acc_idx, N_ACC);
        hung = 1;
      end
      check(mem[C_ADR[7:0]] == s[15:0], "R3/R4 stored sum", mem[C_ADR[7:0]], s[15:0]);
      check(mem[D_ADR[7:0]] == s[15:0], "R5 no-op keeps acc", mem[D_ADR[7:0]], s[15:0]);
      check(mem[F_ADR[7:0]] == v, "R2 load then store", mem[F_ADR[7:0]], v);
      check(acc == v, "R2 acc after load", acc, v);
      check(carry == s[16], "R3 carry kept through load R2", carry, s[16]);
      check(mem[3] == {nop_opc(k), 12'hABC}, "R5 no-op makes no write", mem[3], {nop_opc(k), 12'hABC});
      check(mem[A_ADR[7:0]] == a && mem[B_ADR[7:0]] == b, "R4 only addressed words written",
            {mem[A_ADR[7:0]], mem[B_ADR[7:0]]}, {a, b});
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule